// File: doc/BRIEF.md
# Per-Function Three-Level Address Walker

This block turns a guest-local memory address issued on behalf of one virtual function into a host-local memory address. It does this by walking a table tree held in memory, one level at a time. The first level is a directory with one entry per function. It is indexed by the function number, not by address bits. That entry points at a middle table indexed by the top guest address bits. The middle entry points at a leaf table, and each leaf entry maps one 2 MB host page.

A client presents a function number and a 48-bit guest address through a valid/ready handshake. The walker then issues up to three reads, one after another, on a simple memory port. The first read is based at the `dir_base` input. The walker returns either the translated address or a fault with a cause code. Only one walk is in flight at a time. The result stays presented until the client acknowledges it. The block keeps no translation cache.

Top module: `vf_xlat_walker`

## Requirements
- R1: After reset `req_ready` is 1 and `rsp_valid` and `mem_req_valid` are 0. A request is taken only in a cycle where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 from then until the result is acknowledged, and request inputs that change during a walk do not affect its result.
- R2: A function number of 0 or of 64 and above completes with `rsp_fault`=1, `rsp_cause`=1 and `rsp_haddr`=0, without any memory read.
- R3: The first read is to `dir_base` + 8×function number, with `mem_req_size`=1 (1 means 8 bytes, 0 means 4 bytes).
- R4: Directory and middle entries are 64 bits. Bit 0 is the valid flag and bits 35:4 give the next table base in 64 KB units (base = field << 16). The second read is to that base + 8×guest bits 47:35, size 8 bytes.
- R5: The third read is to the middle entry's table base + 4×guest bits 34:21, with `mem_req_size`=0. The leaf entry is taken from bits 31:0 of `mem_rsp_data`.
- R6: A leaf entry has its valid flag in bit 0 and the host page number in bits 31:5. A full walk returns `rsp_fault`=0, `rsp_cause`=0 and `rsp_haddr` = page << 21 | guest bits 20:0, after exactly three reads.
- R7: A clear valid bit stops the walk at once and returns `rsp_haddr`=0 with `rsp_fault`=1. The cause is 2 for the directory level, 3 for the middle level and 4 for the leaf level. No further reads follow.
- R8: Reserved bits have no effect. These are bits 63:36 and 3:1 of directory and middle entries, bits 4:1 of leaf entries, and bits 63:32 of a leaf response.
- R9: `rsp_valid`, `rsp_fault`, `rsp_cause` and `rsp_haddr` hold steady until `rsp_ack` is sampled at 1. In the next cycle `rsp_valid` is 0 and `req_ready` is 1.
- R10: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the request stays raised, and its address and size stay stable.
- R11: At most one memory read is outstanding. No new read is raised between a read's handshake and its response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dir_base | input | 48 | Byte address of the per-function directory |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_fid | input | 8 | Function number of the request |
| req_gaddr | input | 48 | Guest address to translate |
| rsp_valid | output | 1 | Result present, held until acknowledged |
| rsp_ack | input | 1 | Client takes the result |
| rsp_fault | output | 1 | Walk ended in a fault |
| rsp_cause | output | 3 | 0 none, 1 bad function, 2 directory, 3 middle, 4 leaf |
| rsp_haddr | output | 48 | Translated host address, 0 on fault |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 48 | Byte address of the entry to read |
| mem_req_size | output | 1 | 1 for an 8-byte read, 0 for a 4-byte read |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 64 | Read data, leaf entry in bits 31:0 |

## Verification
The hardest cases to reach from the ports are walks that succeed at the very top of both index ranges, and walks whose entries carry set reserved bits. A wrong index slice or a bad reserved-bit mask only shows up when an entry sits at the exact computed address. The bench therefore fills a sparse memory image with entries at hand-computed addresses. These include middle index 8191 and leaf index 16383 under a maximum table pointer, and entries with every reserved bit set. Any misplaced read then returns an empty word and turns into a visible fault. A memory that holds back `mem_req_ready` for several cycles, and a reset raised in the middle of a walk, cover the stall and abort paths.

// File: rtl/vfx_pkg.sv
// Shared constants and types for the per-function address walker.
// Assumes 48-bit host and guest spaces, 64-bit upper entries, 32-bit leaves.
package vfx_pkg;
    localparam int HAW         = 48;   // host address width
    localparam int GAW         = 48;   // guest address width
    localparam int FID_W       = 8;    // function number width at the port
    localparam int NUM_FN      = 64;   // directory entries (function 0 unused)
    localparam int MID_LSB     = 35;   // lowest guest bit of the middle index
    localparam int LEAF_LSB    = 21;   // lowest guest bit of the leaf index
    localparam int ENTRY_W     = 64;   // width of an upper-level entry
    localparam int PTR_LO      = 4;    // next-table pointer field, low bit
    localparam int PTR_HI      = 35;   // next-table pointer field, high bit
    localparam int PTR_SHIFT   = 16;   // pointer granule: 64 KB
    localparam int PAGE_LO     = 5;    // host page field, low bit
    localparam int PAGE_HI     = 31;   // host page field, high bit
    localparam int UP_STRIDE   = 3;    // log2 bytes per upper entry
    localparam int LEAF_STRIDE = 2;    // log2 bytes per leaf entry
    localparam int UP_VBIT     = 0;    // valid flag of an upper entry
    localparam int LEAF_VBIT   = 0;    // valid flag of a leaf entry

    // Walk level currently being fetched
    typedef enum logic [1:0] {
        LVL_ROOT = 2'd0,
        LVL_MID  = 2'd1,
        LVL_LEAF = 2'd2
    } lvl_e;

    // Result cause codes seen on rsp_cause
    typedef enum logic [2:0] {
        CAUSE_NONE    = 3'd0,
        CAUSE_BAD_FID = 3'd1,
        CAUSE_ROOT    = 3'd2,
        CAUSE_MID     = 3'd3,
        CAUSE_LEAF    = 3'd4
    } cause_e;

    // Walker control states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_DONE  = 2'd3
    } st_e;
endpackage

// File: rtl/vfx_addr_gen.sv
// Entry address generator: forms the byte address and access size of the
// entry fetched at the current level. Purely combinational.
// Assumes table bases are aligned so that base + index*stride never carries
// out of the address width.
module vfx_addr_gen
    import vfx_pkg::*;
#(
    parameter int P_HAW         = HAW,
    parameter int P_FID_W       = FID_W,
    parameter int P_MID_IDX_W   = GAW - MID_LSB,
    parameter int P_LEAF_IDX_W  = MID_LSB - LEAF_LSB,
    parameter int P_UP_STRIDE   = UP_STRIDE,
    parameter int P_LEAF_STRIDE = LEAF_STRIDE
) (
    input  lvl_e                    lvl,
    input  logic [P_HAW-1:0]        dir_base,
    input  logic [P_HAW-1:0]        tbl_base,
    input  logic [P_FID_W-1:0]      fid,
    input  logic [P_MID_IDX_W-1:0]  mid_idx,
    input  logic [P_LEAF_IDX_W-1:0] leaf_idx,
    output logic [P_HAW-1:0]        addr,
    output logic                    size8
);
    logic [P_HAW-1:0] root_off;
    logic [P_HAW-1:0] mid_off;
    logic [P_HAW-1:0] leaf_off;

    // Scale each index by its entry size
    always_comb begin
        root_off = P_HAW'(fid)      << P_UP_STRIDE;
        mid_off  = P_HAW'(mid_idx)  << P_UP_STRIDE;
        leaf_off = P_HAW'(leaf_idx) << P_LEAF_STRIDE;
    end

    // Select base, offset and size by level
    always_comb begin
        case (lvl)
            LVL_ROOT: begin addr = dir_base + root_off; size8 = 1'b1; end
            LVL_MID:  begin addr = tbl_base + mid_off;  size8 = 1'b1; end
            LVL_LEAF: begin addr = tbl_base + leaf_off; size8 = 1'b0; end
            default:  begin addr = tbl_base;            size8 = 1'b1; end
        endcase
    end
endmodule

// File: rtl/vfx_entry_dec.sv
// Entry decoder: extracts the valid flag, the next table base and the host
// page number from a fetched word. Reserved bits are never looked at.
// Assumes the leaf entry occupies the low 32 bits of the read data.
module vfx_entry_dec
    import vfx_pkg::*;
#(
    parameter int P_HAW       = HAW,
    parameter int P_ENTRY_W   = ENTRY_W,
    parameter int P_PTR_LO    = PTR_LO,
    parameter int P_PTR_HI    = PTR_HI,
    parameter int P_PTR_SHIFT = PTR_SHIFT,
    parameter int P_PAGE_LO   = PAGE_LO,
    parameter int P_PAGE_HI   = PAGE_HI,
    parameter int P_UP_VBIT   = UP_VBIT,
    parameter int P_LEAF_VBIT = LEAF_VBIT,
    localparam int PTR_W      = P_PTR_HI - P_PTR_LO + 1,
    localparam int PAGE_W     = P_PAGE_HI - P_PAGE_LO + 1
) (
    input  lvl_e                 lvl,
    input  logic [P_ENTRY_W-1:0] data,
    output logic                 valid,
    output logic [P_HAW-1:0]     next_base,
    output logic [PAGE_W-1:0]    page
);
    logic [PTR_W-1:0] ptr_field;

    // Valid flag position depends on the entry format of the level
    always_comb valid = (lvl == LVL_LEAF) ? data[P_LEAF_VBIT] : data[P_UP_VBIT];

    // Next table base: pointer field scaled to the 64 KB granule
    always_comb begin
        ptr_field = data[P_PTR_HI:P_PTR_LO];
        next_base = P_HAW'({ptr_field, {P_PTR_SHIFT{1'b0}}});
    end

    // Host page number from the low word
    always_comb page = data[P_PAGE_HI:P_PAGE_LO];
endmodule

// File: rtl/vf_xlat_walker.sv
// Per-function three-level address walker (top).
// Takes one request at a time, fetches directory, middle and leaf entries in
// order over a single-outstanding read port and holds the result until
// acknowledged. Assumes dir_base is stable while a walk is in progress and
// that the memory returns exactly one response per accepted read.
module vf_xlat_walker
    import vfx_pkg::*;
#(
    parameter int P_HAW      = HAW,
    parameter int P_GAW      = GAW,
    parameter int P_FID_W    = FID_W,
    parameter int P_NUM_FN   = NUM_FN,
    parameter int P_MID_LSB  = MID_LSB,
    parameter int P_LEAF_LSB = LEAF_LSB,
    parameter int P_ENTRY_W  = ENTRY_W,
    localparam int MID_IDX_W  = P_GAW - P_MID_LSB,
    localparam int LEAF_IDX_W = P_MID_LSB - P_LEAF_LSB,
    localparam int PAGE_W     = PAGE_HI - PAGE_LO + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [P_HAW-1:0]     dir_base,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [P_FID_W-1:0]   req_fid,
    input  logic [P_GAW-1:0]     req_gaddr,
    output logic                 rsp_valid,
    input  logic                 rsp_ack,
    output logic                 rsp_fault,
    output logic [2:0]           rsp_cause,
    output logic [P_HAW-1:0]     rsp_haddr,
    output logic                 mem_req_valid,
    input  logic                 mem_req_ready,
    output logic [P_HAW-1:0]     mem_req_addr,
    output logic                 mem_req_size,
    input  logic                 mem_rsp_valid,
    input  logic [P_ENTRY_W-1:0] mem_rsp_data
);
    st_e                state_q;
    lvl_e               lvl_q;
    logic [P_FID_W-1:0] fid_q;
    logic [P_GAW-1:0]   gaddr_q;
    logic [P_HAW-1:0]   base_q;
    logic [P_HAW-1:0]   haddr_q;
    cause_e             cause_q;
    logic               fid_bad;
    logic               ent_valid;
    logic [P_HAW-1:0]   ent_base;
    logic [PAGE_W-1:0]  ent_page;
    cause_e             lvl_cause;

    // Function number range check; the upper bound vanishes when it cannot be exceeded
    if (P_NUM_FN >= (1 << P_FID_W)) begin : g_fid_full
        assign fid_bad = (req_fid == '0);
    end else begin : g_fid_bounded
        assign fid_bad = (req_fid == '0) || (req_fid >= P_FID_W'(P_NUM_FN));
    end

    // Address of the entry for the current level
    vfx_addr_gen #(
        .P_HAW        (P_HAW),
        .P_FID_W      (P_FID_W),
        .P_MID_IDX_W  (MID_IDX_W),
        .P_LEAF_IDX_W (LEAF_IDX_W)
    ) u_addr (
        .lvl      (lvl_q),
        .dir_base (dir_base),
        .tbl_base (base_q),
        .fid      (fid_q),
        .mid_idx  (gaddr_q[P_GAW-1:P_MID_LSB]),
        .leaf_idx (gaddr_q[P_MID_LSB-1:P_LEAF_LSB]),
        .addr     (mem_req_addr),
        .size8    (mem_req_size)
    );

    // Decode of the word returned by memory
    vfx_entry_dec #(
        .P_HAW     (P_HAW),
        .P_ENTRY_W (P_ENTRY_W)
    ) u_dec (
        .lvl       (lvl_q),
        .data      (mem_rsp_data),
        .valid     (ent_valid),
        .next_base (ent_base),
        .page      (ent_page)
    );

    // Fault cause reported if the current level's entry is not valid
    always_comb begin
        case (lvl_q)
            LVL_ROOT: lvl_cause = CAUSE_ROOT;
            LVL_MID:  lvl_cause = CAUSE_MID;
            default:  lvl_cause = CAUSE_LEAF;
        endcase
    end

    // Walk sequencing: accept, issue, wait, advance or finish, hold result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            lvl_q   <= LVL_ROOT;
            fid_q   <= '0;
            gaddr_q <= '0;
            base_q  <= '0;
            haddr_q <= '0;
            cause_q <= CAUSE_NONE;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        fid_q   <= req_fid;
                        gaddr_q <= req_gaddr;
                        lvl_q   <= LVL_ROOT;
                        if (fid_bad) begin
                            haddr_q <= '0;
                            cause_q <= CAUSE_BAD_FID;
                            state_q <= ST_DONE;
                        end else begin
                            state_q <= ST_ISSUE;
                        end
                    end
                end
                ST_ISSUE: begin
                    if (mem_req_ready) state_q <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (!ent_valid) begin
                            haddr_q <= '0;
                            cause_q <= lvl_cause;
                            state_q <= ST_DONE;
                        end else if (lvl_q == LVL_LEAF) begin
                            haddr_q <= P_HAW'({ent_page, gaddr_q[P_LEAF_LSB-1:0]});
                            cause_q <= CAUSE_NONE;
                            state_q <= ST_DONE;
                        end else begin
                            base_q  <= ent_base;
                            lvl_q   <= (lvl_q == LVL_ROOT) ? LVL_MID : LVL_LEAF;
                            state_q <= ST_ISSUE;
                        end
                    end
                end
                default: begin
                    if (rsp_ack) state_q <= ST_IDLE;
                end
            endcase
        end
    end

    // Port views of the control state
    always_comb begin
        req_ready     = (state_q == ST_IDLE);
        mem_req_valid = (state_q == ST_ISSUE);
        rsp_valid     = (state_q == ST_DONE);
        rsp_fault     = (cause_q != CAUSE_NONE);
        rsp_cause     = cause_q;
        rsp_haddr     = haddr_q;
    end

    // Checker-side record of a read that has been accepted but not answered
    logic rd_open_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                              rd_open_q <= 1'b0;
        else if (mem_req_valid && mem_req_ready) rd_open_q <= 1'b1;
        else if (mem_rsp_valid)                  rd_open_q <= 1'b0;
    end

    assert_accept_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    assert_badfid_direct_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && fid_bad) |=> (rsp_valid && rsp_cause == CAUSE_BAD_FID));

    assert_root_size_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && lvl_q == LVL_ROOT) |-> mem_req_size);

    assert_leaf_size_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && lvl_q == LVL_LEAF) |-> !mem_req_size);

    assert_fault_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_haddr == '0));

    assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ack) |=> (rsp_valid && $stable(rsp_haddr) && $stable(rsp_cause)));

    assert_memreq_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_size)));

    assert_single_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_open_q |-> !mem_req_valid);
endmodule

// File: tb/sim_vf_xlat_walker.sv
`timescale 1ns/1ps
module sim_vf_xlat_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [47:0] dir_base;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [7:0]  req_fid = '0;
    logic [47:0] req_gaddr = '0;
    logic        rsp_valid;
    logic        rsp_ack = 1'b0;
    logic        rsp_fault;
    logic [2:0]  rsp_cause;
    logic [47:0] rsp_haddr;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [47:0] mem_req_addr;
    logic        mem_req_size;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;

    always #4 clk = ~clk;   // 125 MHz

    vf_xlat_walker u0 (.*);

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // Table layout used by the stimulus
    localparam logic [47:0] DIR = 48'h0000_0010_0000;
    localparam logic [47:0] M1  = 48'h0000_0200_0000;
    localparam logic [47:0] L1  = 48'h0000_0400_0000;
    localparam logic [47:0] M2  = 48'h0000_0300_0000;
    localparam logic [47:0] L2  = 48'h0000_0310_0000;
    localparam logic [47:0] M63 = 48'hFFFF_FFFF_0000;
    localparam logic [47:0] L63 = 48'hFFFF_FFFE_0000;
    localparam logic [26:0] P1  = 27'h765_4321;
    localparam logic [26:0] P2  = 27'h000_0001;
    localparam logic [26:0] P63 = 27'h7FF_FFFF;

    localparam logic [47:0] GA0 = {13'd5, 14'h123, 21'h1ABCD};
    localparam logic [47:0] GA1 = {13'd5, 14'h124, 21'h00000};
    localparam logic [47:0] GA2 = {13'd6, 14'h123, 21'h00005};
    localparam logic [47:0] GAX = 48'h1234_5678_9ABC;
    localparam logic [47:0] GA7 = {13'd0, 14'h0, 21'h0FFFFF};
    localparam logic [47:0] GA8 = 48'hFFFF_FFFF_FFFF;
    localparam logic [47:0] GA9 = {13'd5, 14'h123, 21'h00000};

    typedef struct packed {
        logic [7:0]  fid;
        logic [47:0] ga;
        logic        fault;
        logic [2:0]  cause;
        logic [47:0] haddr;
        logic [1:0]  reads;
        logic [3:0]  stall;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{8'd1,   GA0, 1'b0, 3'd0, {P1, 21'h1ABCD},  2'd3, 4'd3},  // R6 full walk, stalled port
        '{8'd1,   GA1, 1'b1, 3'd4, 48'h0,            2'd3, 4'd0},  // R7 leaf invalid
        '{8'd1,   GA2, 1'b1, 3'd3, 48'h0,            2'd2, 4'd0},  // R7 middle invalid
        '{8'd3,   GAX, 1'b1, 3'd2, 48'h0,            2'd1, 4'd0},  // R7 directory invalid
        '{8'd0,   GAX, 1'b1, 3'd1, 48'h0,            2'd0, 4'd0},  // R2 function 0
        '{8'd64,  GAX, 1'b1, 3'd1, 48'h0,            2'd0, 4'd0},  // R2 just above range
        '{8'd200, GAX, 1'b1, 3'd1, 48'h0,            2'd0, 4'd0},  // R2 far above range
        '{8'd2,   GA7, 1'b0, 3'd0, {P2, 21'h0FFFFF}, 2'd3, 4'd0},  // R8 reserved bits set
        '{8'd63,  GA8, 1'b0, 3'd0, 48'hFFFF_FFFF_FFFF, 2'd3, 4'd2}, // R4 R5 top indices
        '{8'd1,   GA9, 1'b0, 3'd0, {P1, 21'h0},      2'd3, 4'd0}   // R6 zero offset
    };

    // Sparse memory image and responder bookkeeping
    logic [63:0] mem_img [logic [47:0]];
    int          nreads = 0;
    int          stall_left = 0;
    bit          have_req = 1'b0;
    logic [47:0] cap_addr;
    logic [47:0] stall_addr;
    bit          stall_seen = 1'b0;
    logic        size_log [4];
    logic [47:0] addr_log [4];

    function automatic void put(input logic [47:0] a, input logic [63:0] d);
        mem_img[a] = d;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Memory model: one read at a time, optional ready stall, response one cycle after acceptance
    initial begin
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            mem_req_ready = 1'b0;
            if (!rst_n) begin
                have_req = 1'b0;
            end else if (have_req) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = mem_img.exists(cap_addr) ? mem_img[cap_addr] : 64'h0;
                have_req = 1'b0;
            end else if (mem_req_valid) begin
                if (stall_left > 0) begin
                    if (!stall_seen) begin stall_addr = mem_req_addr; stall_seen = 1'b1; end
                    stall_left--;
                end else begin
                    if (stall_seen)
                        chk(mem_req_addr == stall_addr, "R10", "address across stall",
                            64'(mem_req_addr), 64'(stall_addr));
                    stall_seen = 1'b0;
                    mem_req_ready = 1'b1;
                    cap_addr = mem_req_addr;
                    if (nreads < 4) begin
                        size_log[nreads] = mem_req_size;
                        addr_log[nreads] = mem_req_addr;
                    end
                    nreads++;
                    have_req = 1'b1;
                end
            end
        end
    end

    // One full transaction: request, distractor during walk, result hold, acknowledge
    task automatic run_walk(input vec_t v);
        int n;
        nreads = 0;
        stall_left = int'(v.stall);
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "ready before request", 64'(req_ready), 64'd1);
        req_valid = 1'b1;
        req_fid   = v.fid;
        req_gaddr = v.ga;
        @(negedge clk);
        req_fid   = 8'd0;              // changed inputs while busy must not matter
        req_gaddr = 48'hAAAA_5555_AAAA;
        chk(req_ready == 1'b0, "R1", "ready while busy", 64'(req_ready), 64'd0);
        n = 0;
        while (!rsp_valid && n < 200) begin
            @(negedge clk);
            n++;
        end
        req_valid = 1'b0;
        chk(rsp_valid == 1'b1, "R9", "result appears", 64'(rsp_valid), 64'd1);
        chk(rsp_fault == v.fault, "R7", "fault flag", 64'(rsp_fault), 64'(v.fault));
        chk(rsp_cause == v.cause, "R7", "cause code", 64'(rsp_cause), 64'(v.cause));
        chk(rsp_haddr == v.haddr, "R6", "host address", 64'(rsp_haddr), 64'(v.haddr));
        chk(nreads == int'(v.reads), "R2", "read count", 64'(nreads), 64'(v.reads));
        for (int i = 0; i < 3; i++) begin
            if (i < nreads)
                chk(size_log[i] == (i < 2), "R5", "access size", 64'(size_log[i]), 64'(i < 2));
        end
        if (nreads > 0)
            chk(addr_log[0] == DIR + 48'(v.fid) * 8, "R3", "directory address",
                64'(addr_log[0]), 64'(DIR + 48'(v.fid) * 8));
        @(negedge clk);
        @(negedge clk);
        chk(rsp_valid && rsp_haddr == v.haddr && rsp_cause == v.cause, "R9", "held before ack",
            {rsp_valid, rsp_cause, 12'h0, rsp_haddr}, {1'b1, v.cause, 12'h0, v.haddr});
        rsp_ack = 1'b1;
        @(negedge clk);
        rsp_ack = 1'b0;
        chk(!rsp_valid && req_ready, "R9", "released after ack",
            {62'h0, rsp_valid, req_ready}, 64'd1);
    endtask

    initial begin
        dir_base = DIR;
        // Directory entries
        put(DIR + 48'd8,   {28'h0,        32'h0000_0200, 4'h1});
        put(DIR + 48'd16,  {28'hFFF_FFFF, 32'h0000_0300, 4'hF});  // R8 reserved bits set
        put(DIR + 48'd24,  {28'h0,        32'h0000_0500, 4'hE});  // pointer present, valid clear
        put(DIR + 48'd504, {28'h0,        32'hFFFF_FFFF, 4'h1});
        // Middle entries
        put(M1 + 48'd40,             {28'h0,        32'h0000_0400, 4'h1});
        put(M2,                      {28'hABC_DEF0, 32'h0000_0310, 4'hF});
        put(M63 + 48'd8191 * 48'd8,  {28'h0,        32'hFFFF_FFFE, 4'h1});
        // Leaf entries, junk in the upper half of the response word
        put(L1 + 48'h123 * 48'd4,    {32'hDEAD_BEEF, P1, 5'h01});
        put(L1 + 48'h124 * 48'd4,    {32'h0,         P1, 5'h1E});  // valid clear
        put(L2,                      {32'hFFFF_FFFF, P2, 5'h1F});
        put(L63 + 48'd16383 * 48'd4, {32'h0,         P63, 5'h01});

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && !rsp_valid && !mem_req_valid, "R1", "reset state",
            {61'h0, req_ready, rsp_valid, mem_req_valid}, 64'd4);

        for (int k = 0; k < NV; k++) run_walk(VECS[k]);

        // Reset in the middle of a walk returns to idle
        nreads = 0;
        @(negedge clk);
        req_valid = 1'b1; req_fid = 8'd1; req_gaddr = GA0;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && !rsp_valid && !mem_req_valid, "R1", "idle after mid-walk reset",
            {61'h0, req_ready, rsp_valid, mem_req_valid}, 64'd4);
        repeat (3) @(negedge clk);
        chk(!mem_req_valid && !rsp_valid, "R11", "no stray read after reset",
            {62'h0, mem_req_valid, rsp_valid}, 64'd0);
        run_walk(VECS[0]);   // recovers with a clean walk

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog: a hang is a failure and still reports the summary
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL R1 watchdog: actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule